// File: doc/BRIEF.md
# Supervisory Watchdog and Reset Sequencer

This block is the timing core of a processor supervisor. An external comparator supplies a synchronous flag that is high while the supply sits below its reset threshold. The block turns that flag and a three-state watchdog input into a stretched reset, with both polarities. It also drives an immediate low-line indication, a watchdog status output and a chip-enable output that is blocked while the supply is low.

The watchdog and reset timers run on a millisecond tick divided down from the system clock. When the external timebase is selected, the watchdog counts rising edges of a slow clock input instead, after passing it through a synchroniser. A watchdog input parked at its mid level turns the watchdog off. The first watchdog period after any reset always uses the long timeout. Later periods follow the timeout-select pin.

Top module: `sup_wdog_core`

## Requirements
- R1: The reset outputs (`rst_no` low, `rst_o` high) are asserted while `rst_ni` is low, and from the clock edge after `low_vcc_i` goes high for as long as it stays high.
- R2: Once `low_vcc_i` clears or `rst_ni` releases, reset holds for the hold time. The hold time is `HOLD_LONG_MS` ticks when `LONG_HOLD`=1 and `HOLD_SHORT_MS` ticks otherwise, each tick being `TICK_DIV` clocks (±1 tick of phase).
- R3: `low_line_no` is the combinational inverse of `low_vcc_i`, with no hold delay in either direction.
- R4: `ce_n_o` equals `ce_n_i` while `low_vcc_i` is low, and is forced high while `low_vcc_i` is high.
- R5: If the enabled watchdog sees no service for a full period, `wdo_no` goes low and a reset pulse of the hold time is issued.
- R6: A change of `wdi_i` between 2'b00 (low) and 2'b01 (high), in either direction, restarts the watchdog period.
- R7: `wdi_i[1]`=1 means disabled (mid level). While disabled the timer stays cleared and `wdo_no` is high. Entering or leaving the disabled state reloads the timer but does not count as service.
- R8: Once `wdo_no` is low it stays low until the next low/high transition of `wdi_i`, and it also returns high whenever `low_vcc_i` is high.
- R9: With `osc_sel_i`=1 (internal timebase), `tsel_i`=0 picks `SHORT_MS` ticks and `tsel_i`=1 picks `LONG_MS` ticks.
- R10: With `osc_sel_i`=0, the period is counted in rising edges of `ext_clk_i`: `EXT_SHORT` edges (`tsel_i`=0) or `EXT_LONG` edges (`tsel_i`=1).
- R11: The first period after any reset uses the long timeout of the selected timebase, whatever `tsel_i` is set to, until the first service transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| low_vcc_i | input | 1 | Supply-below-threshold flag, synchronous |
| wdi_i | input | 2 | Decoded watchdog input: 00 low, 01 high, 1x disabled |
| osc_sel_i | input | 1 | 1 internal ms timebase, 0 external clock |
| tsel_i | input | 1 | Timeout select: 1 long, 0 short |
| ext_clk_i | input | 1 | External timebase clock, asynchronous |
| ce_n_i | input | 1 | Chip-enable in, active low |
| rst_no | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| low_line_no | output | 1 | Low-line indication, active low |
| wdo_no | output | 1 | Watchdog status, low after a timeout |
| ce_n_o | output | 1 | Gated chip-enable, active low |

## Verification
On every cycle the assertions check the following causal links. A low supply forces reset on the next edge, and reset only releases after a cycle with the flag clear. A timeout both raises reset and pulls the status output low, and the status output never falls without a timeout. Service clears the timer, and the disabled level or a low supply returns the status output high. Reset re-arms the long first period. The actual lengths of the hold time and of the short, long and external-edge periods are shown only by the bench's scenarios. So are the reload through the disabled level and the chip-enable gating. The bench checks these by sampling just inside and just outside each computed window.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WDI_LO  = 2'b00,
    WDI_HI  = 2'b01,
    WDI_MID = 2'b10
  } wdi_e;

  function automatic logic wdi_valid(input logic [1:0] w);
    return ~w[1];
  endfunction
endpackage

// File: rtl/sup_timebase.sv
module sup_timebase #(
  parameter int TICK_DIV    = 125000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_sel_i,
  input  logic ext_clk_i,
  output logic ms_tick_o,
  output logic wd_tick_o
);
  localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;
  logic [SYNC_STAGES:0] sync_q;
  logic ext_edge;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                        div_q <= div_q + 1'b1;

  assign ms_tick_o = (div_q == DIV_LAST);

  // synchroniser chain plus one history stage for edge detect
  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= (g == 0) ? ext_clk_i : sync_q[(g == 0) ? 0 : g-1];
    end
  endgenerate

  assign ext_edge  = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign wd_tick_o = osc_sel_i ? ms_tick_o : ext_edge;
endmodule

// File: rtl/sup_rst_seq.sv
module sup_rst_seq #(
  parameter int HOLD_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ms_tick_i,
  input  logic low_vcc_i,
  input  logic wd_timeout_i,
  output logic rst_act_o
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

  logic [HW-1:0] hold_q;
  logic          rst_act_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rst_act_q <= 1'b1;
      hold_q    <= '0;
    end else if (low_vcc_i || wd_timeout_i) begin
      rst_act_q <= 1'b1;
      hold_q    <= '0;
    end else if (rst_act_q && ms_tick_i) begin
      if (hold_q >= HOLD_LAST) begin
        rst_act_q <= 1'b0;
        hold_q    <= '0;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end

  assign rst_act_o = rst_act_q;

  assert_lowvcc_holds_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_vcc_i |=> rst_act_q);
  assert_release_after_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_act_q) |-> !$past(low_vcc_i));
  assert_timeout_resets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_timeout_i |=> rst_act_q);
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer
  import sup_pkg::*;
#(
  parameter int SHORT_MS  = 100,
  parameter int LONG_MS   = 1600,
  parameter int EXT_SHORT = 1011,
  parameter int EXT_LONG  = 4064
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wd_tick_i,
  input  logic       osc_sel_i,
  input  logic       tsel_i,
  input  logic [1:0] wdi_i,
  input  logic       rst_act_i,
  input  logic       low_vcc_i,
  output logic       timeout_o,
  output logic       wdo_low_o
);
  localparam int M1   = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
  localparam int M2   = (EXT_LONG > EXT_SHORT) ? EXT_LONG : EXT_SHORT;
  localparam int MAXP = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXP + 1);

  logic [1:0]    wdi_q;
  logic [CW-1:0] cnt_q, lim;
  logic          first_q, wdo_low_q;
  logic          en, svc, en_chg, use_long;

  assign en       = wdi_valid(wdi_i);
  assign svc      = en && wdi_valid(wdi_q) && (wdi_i[0] != wdi_q[0]);
  assign en_chg   = en != wdi_valid(wdi_q);
  assign use_long = first_q | tsel_i;

  always_comb begin
    if (osc_sel_i) lim = use_long ? CW'(LONG_MS)  : CW'(SHORT_MS);
    else           lim = use_long ? CW'(EXT_LONG) : CW'(EXT_SHORT);
  end

  assign timeout_o = en && !rst_act_i && !svc && !en_chg && wd_tick_i && (cnt_q >= lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wdi_q   <= WDI_MID;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      wdi_q <= wdi_i;
      if (rst_act_i) begin
        cnt_q   <= '0;
        first_q <= 1'b1;
      end else if (svc) begin
        cnt_q   <= '0;
        first_q <= 1'b0;
      end else if (!en || en_chg || timeout_o) begin
        cnt_q <= '0;
      end else if (wd_tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                   wdo_low_q <= 1'b0;
    else if (low_vcc_i || !en || svc) wdo_low_q <= 1'b0;
    else if (timeout_o)            wdo_low_q <= 1'b1;

  assign wdo_low_o = wdo_low_q;

  assert_timeout_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !low_vcc_i) |=> wdo_low_q);
  assert_wdo_needs_timeout_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdo_low_q) |-> $past(timeout_o));
  assert_service_restarts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc |=> (cnt_q == '0));
  assert_disabled_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !wdo_low_q);
  assert_lowline_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_vcc_i |=> !wdo_low_q);
  assert_first_long_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_act_i |=> first_q);
endmodule

// File: rtl/sup_wdog_core.sv
module sup_wdog_core #(
  parameter int TICK_DIV      = 125000,
  parameter bit LONG_HOLD     = 1'b1,
  parameter int HOLD_SHORT_MS = 50,
  parameter int HOLD_LONG_MS  = 200,
  parameter int SHORT_MS      = 100,
  parameter int LONG_MS       = 1600,
  parameter int EXT_SHORT     = 1011,
  parameter int EXT_LONG      = 4064
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       low_vcc_i,
  input  logic [1:0] wdi_i,
  input  logic       osc_sel_i,
  input  logic       tsel_i,
  input  logic       ext_clk_i,
  input  logic       ce_n_i,
  output logic       rst_no,
  output logic       rst_o,
  output logic       low_line_no,
  output logic       wdo_no,
  output logic       ce_n_o
);
  localparam int HOLD_TICKS = LONG_HOLD ? HOLD_LONG_MS : HOLD_SHORT_MS;

  logic ms_tick, wd_tick, wd_timeout, wdo_low, rst_act;

  sup_timebase #(.TICK_DIV(TICK_DIV), .SYNC_STAGES(2)) u_tb (
    .clk_i, .rst_ni, .osc_sel_i, .ext_clk_i,
    .ms_tick_o(ms_tick), .wd_tick_o(wd_tick)
  );

  sup_wd_timer #(
    .SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS),
    .EXT_SHORT(EXT_SHORT), .EXT_LONG(EXT_LONG)
  ) u_wd (
    .clk_i, .rst_ni, .wd_tick_i(wd_tick), .osc_sel_i, .tsel_i, .wdi_i,
    .rst_act_i(rst_act), .low_vcc_i, .timeout_o(wd_timeout), .wdo_low_o(wdo_low)
  );

  sup_rst_seq #(.HOLD_TICKS(HOLD_TICKS)) u_rs (
    .clk_i, .rst_ni, .ms_tick_i(ms_tick), .low_vcc_i,
    .wd_timeout_i(wd_timeout), .rst_act_o(rst_act)
  );

  assign rst_o       = rst_act;
  assign rst_no      = ~rst_act;
  assign low_line_no = ~low_vcc_i;
  assign wdo_no      = ~wdo_low;
  assign ce_n_o      = ce_n_i | low_vcc_i;
endmodule

// File: tb/sim_sup_wdog_core.sv
module sim_sup_wdog_core;
  localparam int D  = 8;
  localparam int H  = 6;
  localparam int S  = 4;
  localparam int L  = 16;
  localparam int XS = 5;
  localparam int XL = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic low_vcc = 1'b0, osc_sel = 1'b1, tsel = 1'b0, ext_clk = 1'b0, ce_n = 1'b0;
  logic [1:0] wdi = 2'b10;
  logic rst_no, rst_o, low_line_no, wdo_no, ce_n_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sup_wdog_core #(
    .TICK_DIV(D), .LONG_HOLD(1'b1), .HOLD_SHORT_MS(3), .HOLD_LONG_MS(H),
    .SHORT_MS(S), .LONG_MS(L), .EXT_SHORT(XS), .EXT_LONG(XL)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .low_vcc_i(low_vcc), .wdi_i(wdi),
    .osc_sel_i(osc_sel), .tsel_i(tsel), .ext_clk_i(ext_clk), .ce_n_i(ce_n),
    .rst_no(rst_no), .rst_o(rst_o), .low_line_no(low_line_no),
    .wdo_no(wdo_no), .ce_n_o(ce_n_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1; tk(4);
    ext_clk = 1'b0; tk(4);
  endtask

  initial begin
    tk(3);
    chk("R1 reset while rst_ni low", rst_no, 1'b0);
    chk("R1 rst_o complement", rst_o, 1'b1);
    chk("R7 wdo high disabled at reset", wdo_no, 1'b1);
    rst_n = 1'b1;
    tk((H-1)*D-1); chk("R2 hold after power-on", rst_no, 1'b0);
    tk(12);        chk("R2 release after power-on", rst_no, 1'b1);
    chk("R2 rst_o low after release", rst_o, 1'b0);

    low_vcc = 1'b1; #1;
    chk("R3 low-line immediate", low_line_no, 1'b0);
    chk("R4 ce forced high", ce_n_o, 1'b1);
    tk(1); chk("R1 reset on low supply", rst_no, 1'b0);
    tk(20); chk("R1 reset held during low supply", rst_no, 1'b0);
    low_vcc = 1'b0; #1;
    chk("R3 low-line returns immediately", low_line_no, 1'b1);
    chk("R4 ce follows low", ce_n_o, 1'b0);
    ce_n = 1'b1; #1; chk("R4 ce follows high", ce_n_o, 1'b1);
    ce_n = 1'b0;
    tk((H-1)*D-1); chk("R2 hold after flag clears", rst_no, 1'b0);
    tk(12);        chk("R2 release after flag clears", rst_no, 1'b1);

    tk(2*L*D);
    chk("R7 disabled never times out", wdo_no, 1'b1);
    chk("R7 disabled no reset", rst_no, 1'b1);

    // first period is long although short selected
    tsel = 1'b0; wdi = 2'b00;
    tk(S*D+5);   chk("R11 first period long (int)", wdo_no, 1'b1);
    tk(81);      chk("R11 before long timeout", wdo_no, 1'b1);
    tk(13);      chk("R5 wdo low after timeout", wdo_no, 1'b0);
    chk("R5 reset pulse after timeout", rst_no, 1'b0);
    tk(29);      chk("R5 pulse lasts hold time", rst_no, 1'b0);
    tk(20);      chk("R5 pulse ends", rst_no, 1'b1);
    chk("R8 wdo stays low without transition", wdo_no, 1'b0);

    wdi = 2'b01;
    tk(1);  chk("R8 wdo cleared by transition", wdo_no, 1'b1);
    tk(21); chk("R9 short period not expired", wdo_no, 1'b1);
    tk(13); chk("R9 short period expired", wdo_no, 1'b0);
    chk("R5 reset after short timeout", rst_no, 1'b0);
    tk(60); chk("R5 reset released", rst_no, 1'b1);

    for (int i = 0; i < 10; i++) begin
      wdi = {1'b0, ~wdi[0]};
      tk(16);
      chk("R6 serviced wdo high", wdo_no, 1'b1);
      chk("R6 serviced no reset", rst_no, 1'b1);
    end

    begin
      logic [1:0] keep;
      keep = wdi;
      wdi = 2'b10; tk(2);
      wdi = keep;
    end
    tk(22); chk("R7 disabled level reloads timer", wdo_no, 1'b1);
    tk(13); chk("R7 reload is not service", wdo_no, 1'b0);
    wdi = 2'b10;
    tk(2);  chk("R7 disabled forces wdo high", wdo_no, 1'b1);
    tk(80); chk("R5 released before long test", rst_no, 1'b1);

    tsel = 1'b1; wdi = 2'b00; tk(10);
    wdi = 2'b01;
    tk(118); chk("R9 long period not expired", wdo_no, 1'b1);
    tk(13);  chk("R9 long period expired", wdo_no, 1'b0);
    wdi = 2'b10; tk(80);

    tsel = 1'b0; wdi = 2'b00; tk(10);
    wdi = 2'b01;
    tk(35); chk("R9 short timeout before low-line", wdo_no, 1'b0);
    low_vcc = 1'b1;
    tk(1);  chk("R8 low-line forces wdo high", wdo_no, 1'b1);
    chk("R1 reset with low-line", rst_no, 1'b0);
    wdi = 2'b10; tk(10);
    low_vcc = 1'b0;
    tk(60); chk("R2 released after low-line", rst_no, 1'b1);

    osc_sel = 1'b0; tsel = 1'b0; wdi = 2'b00; tk(4);
    for (int i = 0; i < XL-1; i++) ext_pulse();
    chk("R11 ext first period long", wdo_no, 1'b1);
    ext_pulse();
    chk("R10 ext long timeout", wdo_no, 1'b0);
    tk(60); chk("R5 ext reset released", rst_no, 1'b1);
    wdi = 2'b01; tk(2);
    chk("R8 ext wdo cleared by transition", wdo_no, 1'b1);
    for (int i = 0; i < XS-1; i++) ext_pulse();
    chk("R10 ext short not expired", wdo_no, 1'b1);
    ext_pulse();
    chk("R10 ext short expired", wdo_no, 1'b0);
    wdi = 2'b10; tk(60);

    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule